// File: doc/BRIEF.md
# Two-Phase Cycle-Count PWM Generator

This block is a single-channel pulse-width generator behind a small 32-bit register bus. Software writes the length of the high phase and the length of the low phase, each as a count of reference-clock cycles, then writes a control word. The control word switches on the phase counter and the output driver, and asks for the staged counts to be committed. The output pin repeats a pattern that is high for the high-phase count and then low for the low-phase count.

Count writes go to staging registers and have no effect on the waveform until a control write with the commit bit set. If the generator is stopped at that moment the new counts are taken at once. If it is running they are held until the current period ends, so no period is cut short or stretched by a mix of old and new values. Three control bits (mode, trigger, invert) are stored and read back but have no effect on the output.

Top module: `cyc_pwm`

## Requirements
- R1: After reset, all three registers read zero and the output is low.
- R2: The control register at offset 0x00 keeps bits 0 (count enable), 2 (mode), 9 (trigger), 10 (invert) and 14 (drive enable). Bit 5 (commit) and all other bits read back as zero.
- R3: Writes to the high count (offset 0x1C) or the low count (offset 0x18) read back at once but leave the output waveform unchanged until a commit.
- R4: A control write with bits 0, 14 and 5 set, made while the generator is stopped, takes the staged counts at once. From the next cycle the output is high for the high count of cycles, then low for the low count, and repeats.
- R5: A commit made while the generator is running takes effect at the end of the current period. The period in progress finishes with the old counts.
- R6: A control write with bit 5 clear commits nothing and does not disturb a running waveform.
- R7: If both counts are zero, or the high count is zero, the output stays low. If only the low count is zero, the output stays high.
- R8: The output is low whenever bit 0 or bit 14 of the control register is clear.
- R9: After the generator is stopped and started again, the waveform restarts at the first cycle of the high phase.
- R10: Setting the mode, trigger or invert bits does not change the output waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, together with bus_sel |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 1 | Generated waveform |

## Verification
The waveform is checked cycle by cycle against a bench model for a set of count pairs. The pairs cover short and long phases, a one-cycle high or low phase, and the three degenerate pairs in which one or both counts are zero. Running those pairs shows that the phase order, the phase lengths and the constant levels are right. Further sequences separate staging from committing. They change the counts without a commit, write the control word with the commit bit clear, commit partway through a period to check that the change waits for the period boundary, stop and restart in the middle of a phase, and set the stored-only control bits.

// File: rtl/cyc_pwm_pkg.sv
// Shared constants for the two-phase PWM: register offsets, control bit
// positions and the phase encoding. Assumes a 32-bit register bus.
package cyc_pwm_pkg;
    localparam int REG_W     = 32;
    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_LOW   = 'h18;
    localparam int OFS_HIGH  = 'h1C;

    localparam int B_RUN  = 0;
    localparam int B_MODE = 2;
    localparam int B_UPD  = 5;
    localparam int B_TRIG = 9;
    localparam int B_INV  = 10;
    localparam int B_DRV  = 14;

    localparam logic [REG_W-1:0] CTRL_KEEP =
        (REG_W'(1) << B_RUN) | (REG_W'(1) << B_MODE) | (REG_W'(1) << B_TRIG) |
        (REG_W'(1) << B_INV) | (REG_W'(1) << B_DRV);

    typedef enum logic {PH_HIGH = 1'b0, PH_LOW = 1'b1} phase_e;
endpackage

// File: rtl/cyc_pwm_regs.sv
// Register file: control word plus staged high/low counts.
// Assumes single-cycle writes qualified by sel & we; reads are combinational.
module cyc_pwm_regs
    import cyc_pwm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              run,
    output logic              commit,
    output logic [CNT_W-1:0]  sh_hi,
    output logic [CNT_W-1:0]  sh_lo
);
    logic [REG_W-1:0] ctrl_q;
    logic hit_ctrl, hit_hi, hit_lo, wr;

    // Address decode for the three mapped registers.
    always_comb begin
        hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
        hit_hi   = (addr == ADDR_W'(OFS_HIGH));
        hit_lo   = (addr == ADDR_W'(OFS_LOW));
        wr       = sel & we;
    end

    // Register writes; only the kept control bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            sh_hi  <= '0;
            sh_lo  <= '0;
        end else if (wr) begin
            if (hit_ctrl) ctrl_q <= wdata & CTRL_KEEP;
            if (hit_hi)   sh_hi  <= wdata[CNT_W-1:0];
            if (hit_lo)   sh_lo  <= wdata[CNT_W-1:0];
        end
    end

    // Commit pulse and the combined run condition.
    always_comb begin
        commit = wr & hit_ctrl & wdata[B_UPD];
        run    = ctrl_q[B_RUN] & ctrl_q[B_DRV];
    end

    // Read mux; unmapped offsets read zero.
    always_comb begin
        if (hit_ctrl)    rdata = ctrl_q;
        else if (hit_hi) rdata = REG_W'(sh_hi);
        else if (hit_lo) rdata = REG_W'(sh_lo);
        else             rdata = '0;
    end
endmodule

// File: rtl/cyc_pwm_seq.sv
// Phase sequencer: active counts, pending commit and the phase counter.
// Assumes commit is a one-cycle pulse; loads at period end or when stopped.
module cyc_pwm_seq
    import cyc_pwm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             commit,
    input  logic [CNT_W-1:0] sh_hi,
    input  logic [CNT_W-1:0] sh_lo,
    output logic [CNT_W-1:0] act_hi,
    output logic [CNT_W-1:0] act_lo,
    output logic             pending,
    output phase_e           phase
);
    logic [CNT_W-1:0] nxt_hi, nxt_lo, cnt;
    logic degen, hi_end, lo_end, boundary;

    // Period-end detection; a zero count makes every cycle a boundary.
    always_comb begin
        degen    = (act_hi == '0) || (act_lo == '0);
        hi_end   = (phase == PH_HIGH) && (cnt == act_hi - CNT_W'(1));
        lo_end   = (phase == PH_LOW)  && (cnt == act_lo - CNT_W'(1));
        boundary = run && (degen || lo_end);
    end

    // Active/pending count management.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_hi  <= '0;
            act_lo  <= '0;
            nxt_hi  <= '0;
            nxt_lo  <= '0;
            pending <= 1'b0;
        end else if (commit && !run) begin
            act_hi  <= sh_hi;
            act_lo  <= sh_lo;
            pending <= 1'b0;
        end else if (commit) begin
            nxt_hi  <= sh_hi;
            nxt_lo  <= sh_lo;
            pending <= 1'b1;
        end else if (pending && (!run || boundary)) begin
            act_hi  <= nxt_hi;
            act_lo  <= nxt_lo;
            pending <= 1'b0;
        end
    end

    // Phase counter; held at the start of the high phase while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || degen) begin
            cnt   <= '0;
            phase <= PH_HIGH;
        end else if (hi_end) begin
            cnt   <= '0;
            phase <= PH_LOW;
        end else if (lo_end) begin
            cnt   <= '0;
            phase <= PH_HIGH;
        end else begin
            cnt   <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/cyc_pwm_drive.sv
// Output stage: derives the pin level from run, phase and the active counts.
// Assumes the sequencer holds PH_HIGH whenever a count is zero.
module cyc_pwm_drive
    import cyc_pwm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             run,
    input  phase_e           phase,
    input  logic [CNT_W-1:0] act_hi,
    input  logic [CNT_W-1:0] act_lo,
    output logic             pwm_out
);
    // Level select: zero high count -> low, zero low count -> high.
    always_comb begin
        if (!run || act_hi == '0) pwm_out = 1'b0;
        else if (act_lo == '0)    pwm_out = 1'b1;
        else                      pwm_out = (phase == PH_HIGH);
    end
endmodule

// File: rtl/cyc_pwm.sv
// Top of the two-phase PWM: register file, sequencer and output stage.
// Assumes a single clock domain; bus reads are combinational.
module cyc_pwm
    import cyc_pwm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              pwm_out
);
    logic             run, commit, pending;
    logic [CNT_W-1:0] sh_hi, sh_lo, act_hi, act_lo;
    phase_e           phase;

    cyc_pwm_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we),
        .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
        .run(run), .commit(commit), .sh_hi(sh_hi), .sh_lo(sh_lo)
    );

    cyc_pwm_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .commit(commit),
        .sh_hi(sh_hi), .sh_lo(sh_lo), .act_hi(act_hi), .act_lo(act_lo),
        .pending(pending), .phase(phase)
    );

    cyc_pwm_drive #(.CNT_W(CNT_W)) u_drive (
        .run(run), .phase(phase), .act_hi(act_hi), .act_lo(act_lo),
        .pwm_out(pwm_out)
    );
endmodule

// File: rtl/cyc_pwm_chk.sv
// Assertion checker for cyc_pwm, attached through bind below.
module cyc_pwm_chk
    import cyc_pwm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              run,
    input logic              commit,
    input logic              pending,
    input logic [CNT_W-1:0]  sh_hi,
    input logic [CNT_W-1:0]  sh_lo,
    input logic [CNT_W-1:0]  act_hi,
    input logic [CNT_W-1:0]  act_lo,
    input logic              pwm_out
);
    p_commit_bit_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_CTRL)) |-> !bus_rdata[B_UPD]);

    p_stopped_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !pwm_out);

    p_idle_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !run) |=> (act_hi == $past(sh_hi) && act_lo == $past(sh_lo)));

    p_counts_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !pending) |=> ($stable(act_hi) && $stable(act_lo)));

    p_restart_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(run) && act_hi != '0 && act_lo != '0) |-> pwm_out);

    p_zero_high_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_hi == '0) |-> !pwm_out);
endmodule

bind cyc_pwm cyc_pwm_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .run(run), .commit(commit), .pending(pending), .sh_hi(sh_hi),
    .sh_lo(sh_lo), .act_hi(act_hi), .act_lo(act_lo), .pwm_out(pwm_out)
);

// File: tb/cyc_pwm_test.sv
module cyc_pwm_test;
    localparam logic [7:0]  A_CTRL = 8'h00;
    localparam logic [7:0]  A_LO   = 8'h18;
    localparam logic [7:0]  A_HI   = 8'h1C;
    localparam logic [31:0] C_RUN  = 32'h0000_0001;
    localparam logic [31:0] C_MODE = 32'h0000_0004;
    localparam logic [31:0] C_UPD  = 32'h0000_0020;
    localparam logic [31:0] C_TRIG = 32'h0000_0200;
    localparam logic [31:0] C_INV  = 32'h0000_0400;
    localparam logic [31:0] C_DRV  = 32'h0000_4000;
    localparam int NVEC = 8;
    // {high count, low count}
    localparam logic [63:0] VEC [0:NVEC-1] = '{
        {32'd3, 32'd5}, {32'd1, 32'd1}, {32'd4, 32'd1}, {32'd1, 32'd6},
        {32'd0, 32'd0}, {32'd0, 32'd4}, {32'd5, 32'd0}, {32'd2, 32'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int n_chk = 0;
    int n_bad = 0;

    // bench model of the requirements
    int m_run = 0, pend = 0, pos = 0;
    int cur_hi = 0, cur_lo = 0, nxt_hi = 0, nxt_lo = 0, s_hi = 0, s_lo = 0;

    always #10 clk = ~clk;

    cyc_pwm uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out)
    );

    function automatic logic exp_out();
        if (m_run == 0 || cur_hi == 0) return 1'b0;
        if (cur_lo == 0) return 1'b1;
        return (pos < cur_hi);
    endfunction

    task automatic load_pend();
        if (pend != 0) begin
            cur_hi = nxt_hi; cur_lo = nxt_lo; pend = 0;
        end
    endtask

    task automatic step_model();
        if (m_run == 0) begin
            pos = 0; load_pend();
        end else if (cur_hi == 0 || cur_lo == 0) begin
            pos = 0; load_pend();
        end else begin
            pos++;
            if (pos == cur_hi + cur_lo) begin
                pos = 0; load_pend();
            end
        end
    endtask

    task automatic check1(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic bus_wr(logic [7:0] a, logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        if (a == A_CTRL && d[5] && m_run == 0) begin
            pos = 0; cur_hi = s_hi; cur_lo = s_lo; pend = 0;
        end else if (a == A_CTRL && d[5]) begin
            step_model(); pend = 1; nxt_hi = s_hi; nxt_lo = s_lo;
        end else begin
            step_model();
        end
        if (a == A_HI) s_hi = int'(d);
        if (a == A_LO) s_lo = int'(d);
        if (a == A_CTRL) m_run = (d[0] && d[14]) ? 1 : 0;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(logic [7:0] a, logic [31:0] exp, string tag);
        bus_addr = a;
        #2;
        check1(tag, bus_rdata, exp);
        #1;
    endtask

    task automatic follow(int n, string tag);
        for (int i = 0; i < n; i++) begin
            check1(tag, {31'd0, pwm_out}, {31'd0, exp_out()});
            @(posedge clk);
            step_model();
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired, all requirements: actual hung expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        bus_rd(A_CTRL, 32'h0, "R1");
        bus_rd(A_HI, 32'h0, "R1");
        bus_rd(A_LO, 32'h0, "R1");
        follow(3, "R1");

        // R4 / R7: table of count pairs, each committed from stopped
        for (int v = 0; v < NVEC; v++) begin
            int h = int'(VEC[v][63:32]);
            int l = int'(VEC[v][31:0]);
            bus_wr(A_CTRL, 32'h0);
            bus_wr(A_HI, VEC[v][63:32]);
            bus_wr(A_LO, VEC[v][31:0]);
            bus_wr(A_CTRL, C_RUN | C_DRV | C_UPD);
            if (h == 0 || l == 0) follow(2 * (h + l) + 4, "R7");
            else                  follow(2 * (h + l) + 3, "R4");
        end

        // R2: control readback keeps only defined bits, commit bit reads zero
        bus_wr(A_CTRL, 32'h0);
        bus_wr(A_CTRL, 32'hFFFF_FFDF);
        bus_rd(A_CTRL, 32'h0000_4605, "R2");
        bus_wr(A_CTRL, C_UPD);
        bus_rd(A_CTRL, 32'h0, "R2");

        // R10: stored-only bits leave the waveform alone
        bus_wr(A_HI, 32'd3);
        bus_wr(A_LO, 32'd2);
        bus_wr(A_CTRL, C_RUN | C_DRV | C_UPD | C_MODE | C_TRIG | C_INV);
        follow(12, "R10");

        // R3: staged writes read back but do not change the output
        bus_wr(A_HI, 32'd7);
        bus_wr(A_LO, 32'd9);
        bus_rd(A_HI, 32'd7, "R3");
        bus_rd(A_LO, 32'd9, "R3");
        follow(10, "R3");

        // R6: control write without commit bit
        bus_wr(A_CTRL, C_RUN | C_DRV);
        follow(10, "R6");

        // R5: commit while running waits for the period boundary
        follow(1, "R5");
        bus_wr(A_CTRL, C_RUN | C_DRV | C_UPD);
        follow(40, "R5");

        // R9: stop mid-phase, restart from the high phase
        follow(3, "R9");
        bus_wr(A_CTRL, 32'h0);
        follow(3, "R9");
        bus_wr(A_CTRL, C_RUN | C_DRV);
        follow(20, "R9");

        // R8: either enable alone keeps the output low
        bus_wr(A_CTRL, C_RUN);
        follow(6, "R8");
        bus_wr(A_CTRL, C_DRV);
        follow(6, "R8");
        bus_wr(A_CTRL, 32'h0);
        follow(3, "R8");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule